// File: doc/BRIEF.md
# Register-Programmed Memory Copy Channel

A single copy channel that moves a programmed number of 16-bit or 32-bit units from a source address to a destination address over a request/acknowledge memory bus. Software programs a source register, a destination register and a control register. Setting the enable bit in the control register, when it was previously clear, arms the channel. Arming loads the working addresses from the programmed registers.

Once the channel is armed, it either starts at once or waits for an external start pulse. The control register selects which. Each unit is one bus read followed by one bus write. Each address steps up, steps down or stays fixed, according to its own mode field. At the end of the transfer the channel clears its enable bit, unless repeat is selected, and it can pulse an interrupt.

Two elaboration parameters choose the processor variant and the channel number. Together they set the width of the count field and the layout of the start-mode field.

Top module: `dma_chan`

## Requirements
- R1: The channel arms only when a control write changes bit 31 from 0 to 1. Arming copies the source and destination registers into the working addresses. A control write while bit 31 is already 1 starts nothing.
- R2: Control bits 18:17 set the destination step: 00 steps up, 01 steps down, 10 holds the address, 11 steps up and reloads the destination register at every start. In modes 00, 01 and 10, a repeated start continues from the working address.
- R3: Control bits 20:19 set the source step: 00 steps up, 01 steps down, 10 holds the address, and 11 behaves as 00.
- R4: When control bit 26 is 1, units are 16-bit, `mem_half` is 1 and addresses step by 2. When it is 0, units are 32-bit and addresses step by 4.
- R5: `start_mode` latches at arming. For the main variant it is {0, bits 29:27}; for the secondary variant it is {2'b10, bits 29:28}. When its low three bits are zero, the transfer starts on the arming edge. Otherwise the channel waits for a `start_req` pulse, which takes effect only while the channel is enabled and idle.
- R6: The unit count is the low CW control bits. CW is 21 for the main variant, 14 for the secondary variant and 16 for secondary channel 3. A zero count means 2^CW units.
- R7: Each unit is a read of the source address followed by a write to the destination address. Each access holds its request, address and direction until it is acknowledged. `busy` is high from the start to completion, and no request is made while the channel is not busy.
- R8: At completion, bit 31 is cleared if control bit 25 is 0. It is kept if bit 25 is 1.
- R9: If control bit 30 is 1, `irq` is high for exactly one cycle, in the cycle when `busy` falls. Otherwise `irq` stays low.
- R10: `reg_sel` addresses the registers: 0 is source, 1 is destination, 2 is control, 3 reads zero. Control readback shows the live enable bit. Control writes made while the channel is busy are ignored.
- R11: The data written for each unit equals the data read for that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| start_req | input | 1 | External start pulse for non-immediate start modes |
| start_mode | output | 4 | Start mode latched at arming |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion interrupt |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_half | output | 1 | 1 = 16-bit access |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions check on every cycle that:
- a waiting access holds its address and direction;
- every acknowledged read is followed by a write;
- the bus is quiet while the channel is idle;
- the interrupt is a single pulse that coincides with `busy` falling;
- a non-repeat transfer leaves its enable clear.

The bench scenarios are what show the arithmetic. They sweep every pairing of source and destination step modes at both unit sizes, with varied acknowledge delays. They also show the zero-count maximum transfer, the difference between destination reload and continuation across repeated starts, the edge-only arming, and the start pulses that are ignored.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter bit SECONDARY = 1'b0,
  parameter int CHAN_NUM  = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        start_req,
  output logic [3:0]  start_mode,
  output logic        busy,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_half,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int CW = SECONDARY ? ((CHAN_NUM == 3) ? 16 : 14) : 21;

  typedef enum logic [1:0] {IDLE, RD, WR} st_t;
  st_t st;

  logic [31:0] src_r, dst_r, ctrl, cur_src, cur_dst, data_r;
  logic [CW:0] rem;
  logic [3:0]  smode;

  wire        wr_ctl = reg_we && reg_sel == 2'd2 && st == IDLE;
  wire        arm    = wr_ctl && !ctrl[31] && reg_wdata[31];
  wire [31:0] ctl_n  = wr_ctl ? reg_wdata : ctrl;
  wire [3:0]  smode_n = SECONDARY ? {2'b10, reg_wdata[29:28]} : {1'b0, reg_wdata[29:27]};
  wire        trig   = !wr_ctl && start_req && ctrl[31] && st == IDLE && smode[2:0] != 3'd0;
  wire        go     = (arm && smode_n[2:0] == 3'd0) || trig;
  wire [CW-1:0] cnt_f = ctl_n[CW-1:0];
  wire [CW:0]   cnt_n = (cnt_f == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cnt_f};
  wire [31:0] unit   = ctrl[26] ? 32'd2 : 32'd4;
  wire        last   = rem == (CW+1)'(1);

  function automatic logic [31:0] stepped(input logic [31:0] a, input logic [1:0] m,
                                          input logic [31:0] u);
    case (m)
      2'b01:   stepped = a - u;
      2'b10:   stepped = a;
      default: stepped = a + u;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      src_r <= '0; dst_r <= '0; ctrl <= '0;
      cur_src <= '0; cur_dst <= '0; data_r <= '0;
      rem <= '0; smode <= '0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (reg_we && reg_sel == 2'd0) src_r <= reg_wdata;
      if (reg_we && reg_sel == 2'd1) dst_r <= reg_wdata;
      if (wr_ctl) ctrl <= reg_wdata;
      if (arm) begin
        cur_src <= src_r;
        cur_dst <= dst_r;
        smode   <= smode_n;
      end
      if (go) begin
        rem <= cnt_n;
        st  <= RD;
        if (trig && ctl_n[18:17] == 2'b11) cur_dst <= dst_r;
      end
      case (st)
        RD: if (mem_ack) begin
          data_r  <= mem_rdata;
          cur_src <= stepped(cur_src, ctrl[20:19], unit);
          st      <= WR;
        end
        WR: if (mem_ack) begin
          cur_dst <= stepped(cur_dst, ctrl[18:17], unit);
          rem     <= rem - (CW+1)'(1);
          if (last) begin
            st <= IDLE;
            if (!ctrl[25]) ctrl[31] <= 1'b0;
            irq <= ctrl[30];
          end else begin
            st <= RD;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy       = st != IDLE;
  assign mem_req    = st != IDLE;
  assign mem_we     = st == WR;
  assign mem_half   = ctrl[26];
  assign mem_addr   = (st == WR) ? cur_dst : cur_src;
  assign mem_wdata  = data_r;
  assign start_mode = smode;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = src_r;
      2'd1:    reg_rdata = dst_r;
      2'd2:    reg_rdata = ctrl;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module dma_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        irq,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] ctrl
);
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R9
  irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $fell(busy));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && mem_we == $past(mem_we) && mem_addr == $past(mem_addr));
  // R7
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req);
  // R7
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> mem_req && mem_we);
  // R8
  once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !ctrl[25] |-> !ctrl[31]);
endmodule

bind dma_chan dma_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .ctrl(ctrl)
);

// File: tb/sim_dma_chan.sv
module sim_dma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, start_req = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [3:0] start_mode;
  logic busy, irq, mem_req, mem_we, mem_half, mem_ack;

  int checks = 0, errors = 0, ack_delay = 0, wcnt = 0;
  int units = 0, irqs = 0;
  logic [31:0] e_src, e_dst, e_ctrl, last_rd;
  bit done = 0;

  localparam logic [31:0] EN = 32'h8000_0000;

  always #10 clk = ~clk;

  dma_chan #(.SECONDARY(1'b1), .CHAN_NUM(0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .start_req(start_req), .start_mode(start_mode), .busy(busy),
    .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  function automatic logic [31:0] f(input logic [31:0] a);
    f = {a[15:0], ~a[15:0]} ^ 32'h3C3C_0F0F;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] a, input logic [1:0] m, input logic sz);
    logic [31:0] u;
    u = sz ? 32'd2 : 32'd4;
    nxt = (m == 2'b01) ? a - u : (m == 2'b10) ? a : a + u;
  endfunction

  assign mem_ack   = mem_req && (wcnt >= ack_delay);
  assign mem_rdata = f(mem_addr);
  always_ff @(posedge clk) wcnt <= (mem_req && !mem_ack) ? wcnt + 1 : 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (irq) irqs++;
    if (mem_req && mem_ack) begin
      chk(mem_half == e_ctrl[26], "R4 size", {31'd0, mem_half}, {31'd0, e_ctrl[26]});
      if (!mem_we) begin
        chk(mem_addr == e_src, "R3 src addr", mem_addr, e_src);
        last_rd = mem_addr;
        e_src = nxt(e_src, e_ctrl[20:19], e_ctrl[26]);
      end else begin
        chk(mem_addr == e_dst, "R2 dst addr", mem_addr, e_dst);
        chk(mem_wdata == f(last_rd), "R11 data", mem_wdata, f(last_rd));
        e_dst = nxt(e_dst, e_ctrl[18:17], e_ctrl[26]);
        units++;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic set_exp(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    e_src = s; e_dst = d; e_ctrl = c; units = 0; irqs = 0;
  endtask

  task automatic pulse_start;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int g;
    logic [31:0] v;
    g = 0;
    while (busy && g < 100000) begin @(negedge clk); g++; end
    chk(g < 100000, "R7 completion", g, 100000);
    @(negedge clk);
    chk(units == n, "R6 unit count", units, n);
    chk(irqs == int'(e_ctrl[30]), "R9 irq pulses", irqs, {31'd0, e_ctrl[30]});
    rd(2'd2, v);
    chk(v[31] == e_ctrl[25], "R8 enable after end", {31'd0, v[31]}, {31'd0, e_ctrl[25]});
  endtask

  task automatic run_imm(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c, input int n);
    wr(2'd2, 32'd0);
    wr(2'd0, s);
    wr(2'd1, d);
    set_exp(s, d, c);
    wr(2'd2, c | EN);
    chk(busy == 1'b1, "R5 immediate start", {31'd0, busy}, 32'd1);
    wait_done(n);
  endtask

  initial begin
    logic [31:0] v, c;
    e_src = 0; e_dst = 0; e_ctrl = 0; last_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !irq && !mem_req, "R7 reset idle", {29'd0, busy, irq, mem_req}, 32'd0);
    rd(2'd2, v); chk(v == 32'd0, "R10 reset ctrl", v, 32'd0);
    chk(start_mode == 4'd0, "R5 reset mode", {28'd0, start_mode}, 32'd0);

    wr(2'd0, 32'hDEAD_BEEF); wr(2'd1, 32'h1234_5678);
    rd(2'd0, v); chk(v == 32'hDEAD_BEEF, "R10 src readback", v, 32'hDEAD_BEEF);
    rd(2'd1, v); chk(v == 32'h1234_5678, "R10 dst readback", v, 32'h1234_5678);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk(v == 32'd0, "R10 sel3 reads zero", v, 32'd0);

    // R2 R3 R4 R6 R9 R11: sweep of step modes and sizes
    for (int dm = 0; dm < 4; dm++)
      for (int sm = 0; sm < 4; sm++)
        for (int sz = 0; sz < 2; sz++) begin
          int n;
          n = 1 + (dm + sm) % 4;
          ack_delay = (dm + sm + sz) % 3;
          c = (32'(sm) << 19) | (32'(dm) << 17) | (32'(sz) << 26) | 32'(n) | ((sm == dm) ? 32'd0 : 32'h4000_0000);
          run_imm(32'h0000_1000 + 32'(sm * 64), 32'h0000_8000 + 32'(dm * 64), c, n);
        end

    // R6: zero count means 2^14 units in the secondary variant
    ack_delay = 0;
    run_imm(32'h0001_0000, 32'h0010_0000, 32'h0400_0000, 16384);

    // R5: deferred start, R8 repeat keeps enable, R2 reload in mode 11
    ack_delay = 1;
    c = 32'h4000_0000 | 32'h0200_0000 | (32'd3 << 17) | (32'd1 << 28) | 32'd2;
    wr(2'd2, 32'd0); wr(2'd0, 32'h3000); wr(2'd1, 32'h5000);
    set_exp(32'h3000, 32'h5000, c);
    wr(2'd2, c | EN);
    chk(!busy, "R5 waits for start", {31'd0, busy}, 32'd0);
    chk(start_mode == 4'b1001, "R5 latched mode", {28'd0, start_mode}, 32'h9);
    repeat (4) @(negedge clk);
    chk(units == 0, "R5 no transfer before start", units, 0);
    pulse_start;
    wait_done(2);
    set_exp(32'h3008, 32'h5000, c);
    pulse_start;
    wait_done(2);

    // R1: rewrite with enable already set does not arm
    c = 32'h0200_0000 | 32'd2;
    set_exp(32'h3010, 32'h5000, c);
    wr(2'd2, c | EN);
    repeat (4) @(negedge clk);
    chk(!busy && units == 0, "R1 no rearm while enabled", units, 0);

    // R2: mode 00 continues across repeated starts
    c = 32'h0200_0000 | (32'd2 << 28) | 32'd3;
    wr(2'd2, 32'd0); wr(2'd0, 32'h7000); wr(2'd1, 32'h9000);
    set_exp(32'h7000, 32'h9000, c);
    wr(2'd2, c | EN);
    chk(start_mode == 4'b1010, "R5 latched mode 2", {28'd0, start_mode}, 32'hA);
    pulse_start;
    wait_done(3);
    set_exp(32'h700C, 32'h900C, c);
    pulse_start;
    wait_done(3);

    // R5: start pulse ignored while disabled
    wr(2'd2, 32'd0);
    set_exp(32'h7018, 32'h9018, c);
    pulse_start;
    repeat (3) @(negedge clk);
    chk(!busy && units == 0, "R5 start ignored when disabled", units, 0);

    // R10: control write ignored while busy
    ack_delay = 3;
    c = 32'h0200_0000 | 32'd4;
    wr(2'd0, 32'hA000); wr(2'd1, 32'hB000);
    set_exp(32'hA000, 32'hB000, c);
    wr(2'd2, c | EN);
    wr(2'd2, 32'd0);
    wait_done(4);
    rd(2'd2, v);
    chk(v == (c | EN), "R10 busy write ignored", v, c | EN);

    // R1: clear then set arms again
    ack_delay = 0;
    c = 32'd1;
    wr(2'd2, 32'd0);
    set_exp(32'hA000, 32'hB000, c);
    wr(2'd2, c | EN);
    chk(busy, "R1 rearm after clear", {31'd0, busy}, 32'd1);
    wait_done(1);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule